// File: doc/BRIEF.md
# I2S Master Audio Transmitter

This block sends stereo audio out of a chip as an I2S master. It divides its input clock down to three outputs: a master clock, a bit clock at one quarter of that rate, and a frame clock that spans 64 bit clocks. The master clock therefore runs at 256 times the sample rate. Each frame carries one left and one right 16-bit sample. Both samples come from a single 32-bit word taken from a 16-entry transmit FIFO.

A DMA engine refills the FIFO through a write port. The block raises a DMA request while the FIFO holds half its depth or less. Control comes in on plain pins: a transmit enable, and a FIFO clear that empties the FIFO and drops the underflow flag. The FIFO occupancy is available as a readback. If a frame starts while the FIFO is empty, the block sends silence and sets a sticky underflow flag.

Top module: `i2s_tx_master`

## Requirements
- R1: `mclk` toggles on every rising edge of `clk` (with the default `MCLK_HALF_LOG2` = 0, the period is 2 `clk` cycles), and `sclk` has a period of 4 `mclk` periods.
- R2: `lrck` has a period of 64 `sclk` periods. It is low for the first 32 (left channel) and high for the last 32 (right channel).
- R3: In each half-frame, the bit captured on the first `sclk` rise after an `lrck` change is 0. The next 16 rises capture the sample MSB first, and the last 15 rises capture 0. `sdo` changes only where `sclk` falls.
- R4: FIFO word bits [31:16] are the left sample and bits [15:0] are the right sample. Words go out one per frame, in the order they were written.
- R5: The FIFO holds 16 words, and `fifo_level` reports how many are stored. A write while the FIFO holds 16 words is dropped.
- R6: `dma_req` is 1 exactly when `fifo_level` is 8 or less.
- R7: When a frame starts with the FIFO empty, the frame is all zeros and `underflow` goes to 1. It stays at 1 until `fifo_clr` is asserted or reset.
- R8: A cycle with `fifo_clr` = 1 leaves `fifo_level` at 0 and `underflow` at 0. A write in the same cycle is dropped.
- R9: While `tx_en` = 0, `mclk`, `sclk`, `lrck` and `sdo` stay 0 and no word leaves the FIFO. Raising `tx_en` starts a frame with the left channel.
- R10: A write and a frame-start read in the same cycle leave `fifo_level` unchanged, and the written word still goes out in its turn.
- R11: After reset, `fifo_level` = 0, `dma_req` = 1, `underflow` = 0, and all serial outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock, divided down to all serial clocks |
| rst_n | input | 1 | Asynchronous reset, active low |
| tx_en | input | 1 | Transmit enable; starts the serial clocks and frames |
| fifo_clr | input | 1 | Synchronous FIFO clear; also clears the underflow flag |
| wr_en | input | 1 | FIFO write strobe from the DMA side |
| wr_data | input | 32 | FIFO word: left sample high, right sample low |
| dma_req | output | 1 | Refill request, high while the FIFO is at most half full |
| fifo_level | output | 5 | Number of words stored in the FIFO |
| underflow | output | 1 | Sticky flag for a frame started with the FIFO empty |
| mclk | output | 1 | Master clock |
| sclk | output | 1 | Bit clock |
| lrck | output | 1 | Frame clock, low for the left channel |
| sdo | output | 1 | Serial data |

## Verification
Two events can land in the same clock edge: the frame-start read of the FIFO and a DMA write. The bench waits for the right half of a frame and counts the `clk` cycles to the last one. It then drives a single write so that it meets the read on the same edge. It judges the result in two ways: the occupancy must not move, and the decoded serial stream must later carry that word right after the words queued before it. A second collision is tested the same way: a clear together with a write, which must leave the FIFO empty.

// File: rtl/i2s_tx_pkg.sv
package i2s_tx_pkg;
   localparam int SCLK_PER_FRAME = 64;
   localparam int SLOTS_PER_HALF = SCLK_PER_FRAME / 2;
   localparam int MCLK_PER_SCLK  = 4;
   localparam int SLOT_W         = $clog2(SCLK_PER_FRAME);

   typedef struct packed {
      logic              mclk;
      logic              sclk;
      logic              lrck;
      logic [SLOT_W-1:0] slot;
   } i2s_timing_t;
endpackage

// File: rtl/i2s_tx_clkgen.sv
module i2s_tx_clkgen
   import i2s_tx_pkg::*;
#(
   parameter int MCLK_HALF_LOG2 = 0
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        tx_en,
   output logic        running,
   output logic        load,
   output i2s_timing_t tim
);
   localparam int MCLK_BIT = MCLK_HALF_LOG2;
   localparam int SCLK_BIT = MCLK_BIT + $clog2(MCLK_PER_SCLK);
   localparam int PW       = SCLK_BIT + 1 + SLOT_W;

   logic [PW-1:0] phase;

   initial begin
      if (MCLK_HALF_LOG2 < 0 || MCLK_HALF_LOG2 > 8)
         $error("MCLK_HALF_LOG2 out of range");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         running <= 1'b0;
         phase   <= '0;
      end else if (!tx_en) begin
         running <= 1'b0;
         phase   <= '0;
      end else begin
         running <= 1'b1;
         if (running) phase <= phase + 1'b1;
      end
   end

   assign load      = tx_en && (!running || (&phase));
   assign tim.mclk  = phase[MCLK_BIT];
   assign tim.sclk  = phase[SCLK_BIT];
   assign tim.slot  = phase[PW-1:SCLK_BIT+1];
   assign tim.lrck  = tim.slot[SLOT_W-1];

   assert_frame_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (running && tx_en && (&phase)) |=> (phase == '0));
endmodule

// File: rtl/i2s_tx_fifo.sv
module i2s_tx_fifo #(
   parameter int DEPTH = 16,
   parameter int WIDTH = 32,
   localparam int AW = $clog2(DEPTH),
   localparam int LW = AW + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             wr,
   input  logic [WIDTH-1:0] wdata,
   input  logic             rd,
   output logic [WIDTH-1:0] rdata,
   output logic             empty,
   output logic [LW-1:0]    level
);
   logic [WIDTH-1:0] mem [DEPTH];
   logic [AW-1:0]    wp, rp;
   logic             do_wr, do_rd;

   initial begin
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0)
         $error("DEPTH must be a power of two, at least 2");
   end

   assign empty = (level == '0);
   assign do_wr = wr && !clr && (level != LW'(DEPTH));
   assign do_rd = rd && !clr && !empty;
   assign rdata = mem[rp];

   for (genvar e = 0; e < DEPTH; e++) begin : g_entry
      always_ff @(posedge clk) begin
         if (do_wr && wp == AW'(e)) mem[e] <= wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp <= '0; rp <= '0; level <= '0;
      end else if (clr) begin
         wp <= '0; rp <= '0; level <= '0;
      end else begin
         if (do_wr) wp <= wp + 1'b1;
         if (do_rd) rp <= rp + 1'b1;
         level <= level + LW'(do_wr) - LW'(do_rd);
      end
   end

   assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
      level <= LW'(DEPTH));
   assert_clr_empties_R8: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (level == '0));
   assert_level_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && rd && !clr && !empty && level != LW'(DEPTH)) |=> $stable(level));
endmodule

// File: rtl/i2s_tx_serializer.sv
module i2s_tx_serializer
   import i2s_tx_pkg::*;
#(
   parameter int SAMPLE_W = 16,
   localparam int WORD_W = 2 * SAMPLE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tx_en,
   input  logic              load,
   input  logic              clr,
   input  logic              fifo_empty,
   input  logic [WORD_W-1:0] fifo_word,
   input  i2s_timing_t       tim,
   output logic              sdo,
   output logic              underflow
);
   localparam int PW = $clog2(SLOTS_PER_HALF);

   logic [WORD_W-1:0]   cur;
   logic [SAMPLE_W-1:0] chan;
   logic [PW-1:0]       pos;

   initial begin
      if (SAMPLE_W < 1 || SAMPLE_W > SLOTS_PER_HALF - 1)
         $error("SAMPLE_W must fit a half-frame after the lead slot");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur       <= '0;
         underflow <= 1'b0;
      end else begin
         if (!tx_en)                       cur <= '0;
         else if (load)                    cur <= (clr || fifo_empty) ? '0 : fifo_word;
         if (clr)                          underflow <= 1'b0;
         else if (load && fifo_empty)      underflow <= 1'b1;
      end
   end

   assign pos  = tim.slot[PW-1:0];
   assign chan = tim.lrck ? cur[SAMPLE_W-1:0] : cur[WORD_W-1:SAMPLE_W];

   always_comb begin
      sdo = 1'b0;
      if (int'(pos) >= 1 && int'(pos) <= SAMPLE_W)
         sdo = chan[SAMPLE_W - int'(pos)];
   end

   assert_pad_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (pos == '0 || int'(pos) > SAMPLE_W) |-> !sdo);
   assert_underflow_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (underflow && !clr) |=> underflow);
endmodule

// File: rtl/i2s_tx_master.sv
module i2s_tx_master
   import i2s_tx_pkg::*;
#(
   parameter int MCLK_HALF_LOG2 = 0,
   parameter int FIFO_DEPTH     = 16,
   parameter int SAMPLE_W       = 16,
   localparam int WORD_W = 2 * SAMPLE_W,
   localparam int LVL_W  = $clog2(FIFO_DEPTH) + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tx_en,
   input  logic              fifo_clr,
   input  logic              wr_en,
   input  logic [WORD_W-1:0] wr_data,
   output logic              dma_req,
   output logic [LVL_W-1:0]  fifo_level,
   output logic              underflow,
   output logic              mclk,
   output logic              sclk,
   output logic              lrck,
   output logic              sdo
);
   i2s_timing_t       tim;
   logic              running, load, f_empty;
   logic [WORD_W-1:0] f_word;

   i2s_tx_clkgen #(.MCLK_HALF_LOG2(MCLK_HALF_LOG2)) u_clk (
      .clk(clk), .rst_n(rst_n), .tx_en(tx_en),
      .running(running), .load(load), .tim(tim));

   i2s_tx_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(WORD_W)) u_fifo (
      .clk(clk), .rst_n(rst_n), .clr(fifo_clr),
      .wr(wr_en), .wdata(wr_data), .rd(load),
      .rdata(f_word), .empty(f_empty), .level(fifo_level));

   i2s_tx_serializer #(.SAMPLE_W(SAMPLE_W)) u_ser (
      .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .load(load), .clr(fifo_clr),
      .fifo_empty(f_empty), .fifo_word(f_word), .tim(tim),
      .sdo(sdo), .underflow(underflow));

   assign dma_req = (fifo_level <= LVL_W'(FIFO_DEPTH / 2));
   assign mclk    = tim.mclk;
   assign sclk    = tim.sclk;
   assign lrck    = tim.lrck;

   assert_dma_threshold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (fifo_level > LVL_W'(FIFO_DEPTH / 2)) |-> !dma_req);
   assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !tx_en |=> (!mclk && !sclk && !lrck && !sdo));
   assert_sdo_edge_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (running && $past(running) && !$stable(sdo)) |-> $fell(sclk));
endmodule

// File: tb/sim_i2s_tx_master.sv
`timescale 1ns/1ps
module sim_i2s_tx_master;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tx_en = 1'b0, fifo_clr = 1'b0, wr_en = 1'b0;
   logic [31:0] wr_data = '0;
   logic        dma_req, underflow, mclk, sclk, lrck, sdo;
   logic [4:0]  fifo_level;

   int checks = 0, failures = 0, cycles = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   i2s_tx_master u0 (
      .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .fifo_clr(fifo_clr),
      .wr_en(wr_en), .wr_data(wr_data), .dma_req(dma_req),
      .fifo_level(fifo_level), .underflow(underflow),
      .mclk(mclk), .sclk(sclk), .lrck(lrck), .sdo(sdo));

   // serial stream decoder, acting as the receiver
   bit          dec_rst = 1;
   logic        d_psclk, d_lr;
   int          d_pos, d_cnt;
   bit          pad_err;
   logic [15:0] acc, left;
   logic [31:0] frames [32];

   always @(negedge clk) begin
      if (dec_rst) begin
         d_psclk = 0; d_lr = 1; d_pos = 0; d_cnt = 0; pad_err = 0; acc = 0;
      end else begin
         if (sclk && !d_psclk) begin
            if (lrck != d_lr) begin d_lr = lrck; d_pos = 0; acc = 0; end
            else d_pos = d_pos + 1;
            if (d_pos >= 1 && d_pos <= 16) acc = {acc[14:0], sdo};
            else if (sdo) pad_err = 1;
            if (d_pos == 31) begin
               if (!lrck) left = acc;
               else if (d_cnt < 32) begin frames[d_cnt] = {left, acc}; d_cnt++; end
            end
         end
         d_psclk = sclk;
      end
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000 && !done) begin
         failures++;
         $display("FAIL watchdog: run did not finish, actual cycles=%0d expected <150000", cycles);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic push(input logic [31:0] w);
      wr_en = 1; wr_data = w; cyc(1); wr_en = 0;
   endtask

   task automatic stop_and_clear();
      tx_en = 0; dec_rst = 1; fifo_clr = 1; cyc(2); fifo_clr = 0; cyc(1);
   endtask

   task automatic start();
      dec_rst = 0; tx_en = 1;
   endtask

   // R11: reset state
   task automatic t_reset();
      check(fifo_level == 0 && dma_req && !underflow, "R11 status", {fifo_level, dma_req, underflow}, 6'b000010);
      check(!mclk && !sclk && !lrck && !sdo, "R11 serial", {mclk, sclk, lrck, sdo}, 0);
   endtask

   // R9: disabled block is quiet and leaves the FIFO alone
   task automatic t_idle();
      int toggles = 0;
      push(32'h1111_2222); push(32'h3333_4444);
      for (int i = 0; i < 200; i++) begin
         cyc(1);
         if (mclk || sclk || lrck || sdo) toggles++;
      end
      check(toggles == 0, "R9 outputs low while disabled", toggles, 0);
      check(fifo_level == 2, "R9 no read while disabled", fifo_level, 2);
   endtask

   // R1, R2: clock ratios
   task automatic t_clocks();
      int n, pm, ps;
      start();
      cyc(40);
      pm = mclk; n = 0;
      while (!(mclk && !pm)) begin pm = mclk; cyc(1); end
      pm = mclk; cyc(1); n = 1;
      while (!(mclk && !pm)) begin pm = mclk; cyc(1); n++; end
      check(n == 2, "R1 mclk period in clk", n, 2);
      ps = sclk;
      while (!(sclk && !ps)) begin ps = sclk; cyc(1); end
      n = 0; ps = sclk; pm = mclk;
      cyc(1);
      while (!(sclk && !ps)) begin if (mclk && !pm) n++; ps = sclk; pm = mclk; cyc(1); end
      if (mclk && !pm) n++;
      check(n == 4, "R1 mclk per sclk", n, 4);
      pm = lrck;
      while (!(lrck && !pm)) begin pm = lrck; cyc(1); end
      n = 0; pm = lrck; ps = sclk;
      cyc(1);
      while (!(lrck && !pm)) begin if (sclk && !ps) n++; pm = lrck; ps = sclk; cyc(1); end
      if (sclk && !ps) n++;
      check(n == 64, "R2 sclk per lrck period", n, 64);
   endtask

   // R3, R4, R7: data order, mapping, underflow
   task automatic t_data();
      logic [31:0] w [4] = '{32'h8001_7FFE, 32'hA5C3_0F0F, 32'hFFFF_0000, 32'h1234_ABCD};
      for (int i = 0; i < 4; i++) push(w[i]);
      check(!underflow, "R7 no underflow before start", underflow, 0);
      start();
      cyc(512 * 5 + 600);
      check(d_cnt >= 5, "R4 frames decoded", d_cnt, 5);
      for (int i = 0; i < 4; i++)
         check(frames[i] == w[i], "R4 word order and channel mapping", frames[i], w[i]);
      check(frames[4] == 0, "R7 zeros on empty FIFO", frames[4], 0);
      check(underflow, "R7 underflow set", underflow, 1);
      check(!pad_err, "R3 padding slots zero", pad_err, 0);
      cyc(600);
      check(underflow, "R7 underflow sticky", underflow, 1);
   endtask

   // R5, R6: depth, overflow drop, request threshold
   task automatic t_full();
      for (int i = 0; i < 8; i++) push(32'h0100_0000 * (i + 1) + i);
      check(fifo_level == 8 && dma_req, "R6 request at half", {fifo_level, dma_req}, {5'd8, 1'b1});
      push(32'h0900_0008);
      check(fifo_level == 9 && !dma_req, "R6 no request above half", {fifo_level, dma_req}, {5'd9, 1'b0});
      for (int i = 9; i < 17; i++) push(32'h0100_0000 * (i + 1) + i);
      check(fifo_level == 16, "R5 level capped at depth", fifo_level, 16);
      start();
      cyc(512 * 17 + 600);
      for (int i = 0; i < 16; i++)
         check(frames[i] == 32'h0100_0000 * (i + 1) + i, "R5 stored words", frames[i], 32'h0100_0000 * (i + 1) + i);
      check(frames[16] == 0, "R5 write when full dropped", frames[16], 0);
      check(fifo_level == 0 && dma_req, "R6 request when drained", {fifo_level, dma_req}, 6'b000001);
   endtask

   // R8: clear empties, clears underflow, beats a write
   task automatic t_clear();
      check(underflow, "R8 precondition underflow", underflow, 1);
      push(32'hDEAD_BEEF); push(32'hCAFE_F00D);
      fifo_clr = 1; wr_en = 1; wr_data = 32'h5555_AAAA; cyc(1);
      fifo_clr = 0; wr_en = 0;
      check(fifo_level == 0, "R8 clear wins over write", fifo_level, 0);
      check(!underflow, "R8 underflow cleared", underflow, 0);
   endtask

   // R10: write lands on the frame-start read edge
   task automatic t_collide();
      logic [31:0] w [3] = '{32'h0001_0002, 32'h0003_0004, 32'h0005_0006};
      for (int i = 0; i < 3; i++) push(w[i]);
      start();
      cyc(2);
      while (!lrck) cyc(1);
      cyc(255);
      check(fifo_level == 2, "R10 level before collision", fifo_level, 2);
      wr_en = 1; wr_data = 32'h7777_8888; cyc(1); wr_en = 0;
      check(fifo_level == 2, "R10 level unchanged by write and read", fifo_level, 2);
      cyc(512 * 4 + 600);
      check(frames[0] == w[0] && frames[1] == w[1] && frames[2] == w[2], "R10 earlier words", frames[2], w[2]);
      check(frames[3] == 32'h7777_8888, "R10 colliding word sent", frames[3], 32'h7777_8888);
   endtask

   initial begin
      cyc(3);
      t_reset();
      rst_n = 1;
      cyc(2);
      t_reset();
      t_idle();
      stop_and_clear();
      t_clocks();
      stop_and_clear();
      t_data();
      tx_en = 0; dec_rst = 1; cyc(2);
      t_clear();
      stop_and_clear();
      t_full();
      stop_and_clear();
      t_collide();
      stop_and_clear();
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule